// File: doc/BRIEF.md
# Dual-Mode SHA-1 / SHA-256 Compression Core

This block compresses 512-bit message blocks with SHA-1 or SHA-256. It runs one round per clock. The caller pads the message beforehand. Each block is then written as sixteen 32-bit words on a valid/ready word port. Every word is taken as little-endian and has its bytes reversed before it is hashed. A one-cycle `new_hash` pulse samples the `mode` input and loads the initial chaining value for that algorithm. Any number of blocks can follow, and the chaining value carries from one block to the next.

The core has two 16-word message stores: an input buffer and the compression window. A block in the input buffer moves into the window when the engine goes idle. This frees the input buffer, so the next block can be written while the current one is compressed. After each block, `digest_valid` rises and `digest` shows the updated chaining value.

Top module: `sha_dual_core`

## Requirements
- R1: After reset, `digest_valid` and `busy` are 0 and `wr_ready` is 1.
- R2: Each accepted word has its bytes reversed before hashing. A word written as 0x64636261 is hashed as the big-endian word 0x61626364.
- R3: In SHA-1 mode (`mode`=0 at `new_hash`), the 160-bit digest appears on `digest[255:96]` and `digest[95:0]` is zero. For the padded "abc" block the digest is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R4: In SHA-256 mode (`mode`=1 at `new_hash`), all 256 bits of `digest` hold the result. For the padded "abc" block it is ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R5: The chaining value carries across blocks. For the two-block, 448-bit message "abcdbcde...nopq" the SHA-1 result is 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1. The SHA-256 result is 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R6: `digest_valid` rises N+2 clock edges after the edge that accepts a block's 16th word, with N = 80 for SHA-1 and N = 64 for SHA-256. This is one start cycle, N rounds and one addition cycle. `busy` falls on the same edge.
- R7: A `new_hash` pulse while idle clears `digest_valid`, latches `mode`, and puts the initial value on `digest`. For SHA-256 that value is 6a09e667 bb67ae85 3c6ef372 a54ff53a 510e527f 9b05688c 1f83d9ab 5be0cd19. For SHA-1 it is 67452301 efcdab89 98badcfe 10325476 c3d2e1f0 followed by zeros.
- R8: A `new_hash` pulse while `busy` is 1 is ignored. The current digest, its chaining value and the latched mode are unaffected.
- R9: A second block can be written while a block is compressing. `wr_ready` is 0 only while a full block waits in the input buffer. A waiting block starts, with `busy` 1, on the edge after the idle edge where `digest_valid` rose.
- R10: `digest_valid` falls on the edge where a new block starts. While idle, it stays 1 and `digest` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Algorithm, sampled at `new_hash`: 0 = SHA-1, 1 = SHA-256 |
| new_hash | input | 1 | One-cycle pulse: load the initial chaining value |
| wr_valid | input | 1 | Word write request |
| wr_data | input | 32 | Message word, little-endian byte order |
| wr_ready | output | 1 | Input buffer can take a word |
| busy | output | 1 | A block is being compressed |
| digest_valid | output | 1 | `digest` holds a finished chaining value |
| digest | output | 256 | Chaining value, word 0 in the top bits |

## Verification
The hardest state to reach from the ports is the one where both stores hold data: a full block waits in the input buffer while another is mid-compression, and the handover happens on the edge after completion. The bench writes the second block of a message straight after the first, without waiting for `digest_valid`. This stalls the writer on `wr_ready` and lets it observe the handover edge. Further messages of one to three pseudo-random blocks are streamed back to back in both modes and compared with a behavioural model written in the bench. The model is anchored by the four standard digests.

// File: rtl/sha_dual_core.sv
module sha_dual_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         new_hash,
  input  logic         wr_valid,
  input  logic [31:0]  wr_data,
  output logic         wr_ready,
  output logic         busy,
  output logic         digest_valid,
  output logic [255:0] digest
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_ADD} state_t;

  localparam logic [255:0] IV_S1 = {160'h67452301efcdab8998badcfe10325476c3d2e1f0, 96'h0};
  localparam logic [255:0] IV_S2 = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [31:0] KT [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic logic [31:0] ror(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  state_t      st;
  logic        mode_q;
  logic        in_full;
  logic [3:0]  wptr;
  logic [6:0]  rnd;
  logic [31:0] ibuf [16];
  logic [31:0] win  [16];
  logic [31:0] hv   [8];
  logic [31:0] vv   [8];
  logic [31:0] nv   [8];
  logic [31:0] w_next, f1, k1, t1, t2;

  wire accept = wr_valid && wr_ready;
  wire start  = (st == S_IDLE) && !new_hash && in_full;
  wire last   = rnd == (mode_q ? 7'd63 : 7'd79);

  assign wr_ready = !in_full;
  assign busy     = st != S_IDLE;
  assign digest   = {hv[0], hv[1], hv[2], hv[3], hv[4], hv[5], hv[6], hv[7]};

  always_comb begin
    f1 = '0;
    k1 = '0;
    t1 = '0;
    t2 = '0;
    if (mode_q) begin
      w_next = (ror(win[14], 17) ^ ror(win[14], 19) ^ (win[14] >> 10)) + win[9]
             + (ror(win[1], 7) ^ ror(win[1], 18) ^ (win[1] >> 3)) + win[0];
      t1 = vv[7] + (ror(vv[4], 6) ^ ror(vv[4], 11) ^ ror(vv[4], 25))
         + ((vv[4] & vv[5]) ^ (~vv[4] & vv[6])) + KT[rnd[5:0]] + win[0];
      t2 = (ror(vv[0], 2) ^ ror(vv[0], 13) ^ ror(vv[0], 22))
         + ((vv[0] & vv[1]) ^ (vv[0] & vv[2]) ^ (vv[1] & vv[2]));
      nv = '{t1 + t2, vv[0], vv[1], vv[2], vv[3] + t1, vv[4], vv[5], vv[6]};
    end else begin
      w_next = ror(win[13] ^ win[8] ^ win[2] ^ win[0], 31);
      if (rnd < 7'd20) begin
        f1 = (vv[1] & vv[2]) | (~vv[1] & vv[3]);
        k1 = 32'h5a827999;
      end else if (rnd < 7'd40) begin
        f1 = vv[1] ^ vv[2] ^ vv[3];
        k1 = 32'h6ed9eba1;
      end else if (rnd < 7'd60) begin
        f1 = (vv[1] & vv[2]) | (vv[1] & vv[3]) | (vv[2] & vv[3]);
        k1 = 32'h8f1bbcdc;
      end else begin
        f1 = vv[1] ^ vv[2] ^ vv[3];
        k1 = 32'hca62c1d6;
      end
      t1 = ror(vv[0], 27) + f1 + vv[4] + k1 + win[0];
      nv = '{t1, vv[0], ror(vv[1], 2), vv[2], vv[3], vv[5], vv[6], vv[7]};
    end
  end

  always_ff @(posedge clk) begin
    if (accept) ibuf[wptr] <= {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]};
    if (start) win <= ibuf;
    else if (st == S_RUN) begin
      for (int i = 0; i < 15; i++) win[i] <= win[i+1];
      win[15] <= w_next;
    end
    if (start) vv <= hv;
    else if (st == S_RUN) vv <= nv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      mode_q       <= 1'b0;
      in_full      <= 1'b0;
      wptr         <= '0;
      rnd          <= '0;
      digest_valid <= 1'b0;
      for (int i = 0; i < 8; i++) hv[i] <= IV_S1[255-32*i -: 32];
    end else begin
      if (accept) begin
        wptr <= wptr + 4'd1;
        if (wptr == 4'd15) in_full <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          if (new_hash) begin
            mode_q       <= mode;
            digest_valid <= 1'b0;
            for (int i = 0; i < 8; i++) hv[i] <= mode ? IV_S2[255-32*i -: 32] : IV_S1[255-32*i -: 32];
          end else if (in_full) begin
            in_full      <= 1'b0;
            digest_valid <= 1'b0;
            rnd          <= '0;
            st           <= S_RUN;
          end
        end
        S_RUN: begin
          rnd <= rnd + 7'd1;
          if (last) st <= S_ADD;
        end
        default: begin
          for (int i = 0; i < 8; i++) hv[i] <= hv[i] + vv[i];
          digest_valid <= 1'b1;
          st           <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module sha_dual_core_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         new_hash,
  input logic         wr_ready,
  input logic         busy,
  input logic         digest_valid,
  input logic [255:0] digest
);
  a_r6_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(digest_valid) |-> $fell(busy));
  a_r10_valid_drops_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !digest_valid);
  a_r9_waiting_block_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !busy && !new_hash) |=> busy);
  a_r8_digest_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(digest) || $rose(digest_valid)));
  a_r7_new_hash_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (new_hash && !busy) |=> !digest_valid);
endmodule

bind sha_dual_core sha_dual_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .new_hash(new_hash), .wr_ready(wr_ready),
  .busy(busy), .digest_valid(digest_valid), .digest(digest));

// File: tb/sha_dual_core_tb.sv
`timescale 1ns/1ps
module sha_dual_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic new_hash = 1'b0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready, busy, digest_valid;
  logic [255:0] digest;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sha_dual_core u_dut (.*);

  localparam logic [255:0] D1_ABC = {160'ha9993e364706816aba3e25717850c26c9cd0d89d, 96'h0};
  localparam logic [255:0] D2_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] D1_TWO = {160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1, 96'h0};
  localparam logic [255:0] D2_TWO = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;
  localparam logic [255:0] IV1 = {160'h67452301efcdab8998badcfe10325476c3d2e1f0, 96'h0};
  localparam logic [255:0] IV2 = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
  localparam logic [31:0] KB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  logic [31:0] msg [4][16];

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_hash(input bit m, input int nb);
    logic [31:0] h [8];
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, g, hh, t, u, fn, kk;
    for (int i = 0; i < 8; i++) h[i] = m ? IV2[255-32*i -: 32] : IV1[255-32*i -: 32];
    for (int bl = 0; bl < nb; bl++) begin
      for (int i = 0; i < 16; i++) w[i] = msg[bl][i];
      a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4]; f = h[5]; g = h[6]; hh = h[7];
      if (m) begin
        for (int i = 16; i < 64; i++)
          w[i] = (rr(w[i-2], 17) ^ rr(w[i-2], 19) ^ (w[i-2] >> 10)) + w[i-7]
               + (rr(w[i-15], 7) ^ rr(w[i-15], 18) ^ (w[i-15] >> 3)) + w[i-16];
        for (int i = 0; i < 64; i++) begin
          t = hh + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KB[i] + w[i];
          u = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
          hh = g; g = f; f = e; e = d + t; d = c; c = b; b = a; a = t + u;
        end
        h[5] += f; h[6] += g; h[7] += hh;
      end else begin
        for (int i = 16; i < 80; i++) w[i] = rr(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 31);
        for (int i = 0; i < 80; i++) begin
          if (i < 20)      begin fn = (b & c) | (~b & d);          kk = 32'h5a827999; end
          else if (i < 40) begin fn = b ^ c ^ d;                   kk = 32'h6ed9eba1; end
          else if (i < 60) begin fn = (b & c) | (b & d) | (c & d); kk = 32'h8f1bbcdc; end
          else             begin fn = b ^ c ^ d;                   kk = 32'hca62c1d6; end
          t = rr(a, 27) + fn + e + kk + w[i];
          e = d; d = c; c = rr(b, 2); b = a; a = t;
        end
      end
      h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
    end
    return {h[0], h[1], h[2], h[3], h[4], h[5], h[6], h[7]};
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] be);
    wr_data  = {be[7:0], be[15:8], be[23:16], be[31:24]};
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic put_block(input int bl);
    for (int i = 0; i < 16; i++) put(msg[bl][i]);
  endtask

  task automatic hash_start(input bit m);
    mode = m; new_hash = 1'b1;
    @(negedge clk);
    new_hash = 1'b0;
  endtask

  task automatic finish_wait;
    int n = 0;
    while (!(digest_valid && wr_ready && !busy) && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic count_to_valid(output int n);
    n = 0;
    while (!digest_valid && n < 400) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic fill_abc;
    for (int i = 0; i < 16; i++) msg[0][i] = '0;
    msg[0][0] = 32'h61626380; msg[0][15] = 32'h18;
  endtask

  task automatic fill_two;
    for (int i = 0; i < 14; i++)
      msg[0][i] = {8'h61 + 8'(i), 8'h62 + 8'(i), 8'h63 + 8'(i), 8'h64 + 8'(i)};
    msg[0][14] = 32'h80000000; msg[0][15] = '0;
    for (int i = 0; i < 16; i++) msg[1][i] = '0;
    msg[1][15] = 32'h1c0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [255:0] snap;
    logic [31:0] seed = 32'h1234abcd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset flags", {253'h0, digest_valid, busy, wr_ready}, 256'h1);

    // R4 R6 R2: single SHA-256 block, latency and byte order
    hash_start(1'b1);
    fill_abc; put_block(0);
    count_to_valid(n);
    chk("R6 sha256 latency", 256'(n), 256'd66);
    chk("R4 R2 sha256 abc", digest, D2_ABC);
    snap = digest;
    repeat (5) @(negedge clk);
    chk("R10 valid held idle", {255'h0, digest_valid}, 256'h1);
    chk("R10 digest stable idle", digest, snap);

    // R7 initial values
    hash_start(1'b1);
    chk("R7 valid cleared", {255'h0, digest_valid}, 256'h0);
    chk("R7 sha256 iv", digest, IV2);
    hash_start(1'b0);
    chk("R7 sha1 iv", digest, IV1);

    // R3 R6 SHA-1 single block
    fill_abc; put_block(0);
    count_to_valid(n);
    chk("R6 sha1 latency", 256'(n), 256'd82);
    chk("R3 sha1 abc", digest, D1_ABC);

    // R8 new_hash while busy ignored
    hash_start(1'b0);
    put_block(0);
    repeat (10) @(negedge clk);
    mode = 1'b1; new_hash = 1'b1;
    @(negedge clk);
    new_hash = 1'b0;
    finish_wait;
    chk("R8 ignored new_hash", digest, D1_ABC);

    // R5 SHA-1 two blocks
    hash_start(1'b0);
    fill_two; put_block(0); put_block(1);
    finish_wait;
    chk("R5 sha1 two-block", digest, D1_TWO);

    // R9 R5 SHA-256 two blocks with overlap
    hash_start(1'b1);
    put_block(0); put_block(1);
    chk("R9 ready low while waiting", {254'h0, busy, wr_ready}, 256'h2);
    n = 0;
    while (!digest_valid && n < 400) begin @(negedge clk); n++; end
    @(negedge clk);
    chk("R9 R10 queued block started", {254'h0, busy, digest_valid}, 256'h2);
    finish_wait;
    chk("R5 sha256 two-block", digest, D2_TWO);

    // sweep: pseudo-random chains against the bench model
    for (int m = 0; m < 2; m++) begin
      for (int nb = 1; nb <= 3; nb++) begin
        for (int bl = 0; bl < nb; bl++)
          for (int i = 0; i < 16; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            msg[bl][i] = seed;
          end
        hash_start(m[0]);
        for (int bl = 0; bl < nb; bl++) put_block(bl);
        finish_wait;
        chk(m ? "R4 R5 sweep sha256" : "R3 R5 sweep sha1", digest, ref_hash(m[0], nb));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule